// File: doc/BRIEF.md
# Strip-Mined Vector Sum Reduction Engine

This block adds up a stream of N integer operands of any length with a fixed set of VL parallel partial sums. A start pulse loads the operand count and clears the partials. Operands then arrive one chunk per ready/valid beat, with VL lanes per beat. Each chunk is added lane by lane into the partials. The first beat carries the short chunk of N mod VL elements. Every beat after it is full.

Once the last chunk has been taken, the engine folds the partial-sum vector onto itself. On each fold step the upper half of the active length is added into the lower half and the active length is halved. After log2(VL) steps lane 0 holds the total. The engine then presents the total with a one-cycle done pulse. A host uses it where a long dot product or vector sum has to be turned into one scalar without a serial accumulator chain.

Top module: `vec_sum_reduce`

## Requirements
- R1: After reset, done_o and opReady_o are both low, and they stay low until a start is accepted.
- R2: For N greater than zero, the engine accepts exactly ceil(N/VL) operand beats. A beat is taken on a clock edge where opValid_i and opReady_o are both high.
- R3: When N mod VL is not zero, the first beat carries that many elements in lanes 0 upward, where lane j occupies opData_i bits [j*DATA_W +: DATA_W]. Lanes at or above that count are ignored.
- R4: Every beat after the first, and the first beat when N is a multiple of VL, carries VL valid elements in all lanes.
- R5: The result is the sum of all N valid elements modulo 2^DATA_W. Overflow is not flagged.
- R6: The fold phase takes exactly log2(VL) cycles. done_o is high in the cycle that begins log2(VL) clock edges after the edge that took the last beat.
- R7: With N equal to zero, opReady_o never rises and the result is 0. done_o is high log2(VL) edges after the edge that accepted the start.
- R8: done_o is high for exactly one cycle per run, and result_o is valid in that cycle.
- R9: A start pulse that arrives while a run is in progress has no effect on that run's beat count or result.
- R10: Each accepted start clears all partial sums, so no residue from a previous run reaches the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; sampled only while idle |
| len_i | input | CNT_W | Operand count N, sampled with start_i |
| opValid_i | input | 1 | Operand chunk valid |
| opReady_o | output | 1 | Engine can take a chunk |
| opData_i | input | VL*DATA_W | Operand chunk, lane j at bits [j*DATA_W +: DATA_W] |
| result_o | output | DATA_W | Reduced total, valid while done_o is high |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check the following on every cycle:
- the fold phase never runs past log2(VL) steps, and it reaches the done state on exactly that count;
- done never lasts two cycles;
- a stray start does not disturb the remaining-element count;
- a start clears every partial;
- lanes outside a short chunk keep their value.

The arithmetic end result can only be shown by the bench's scenarios. The bench sweeps N across a small configuration, so that every remainder value, multiples of VL, zero length, bubbles on the valid line, and a start injected mid-run are all exercised. Each total is checked against a sum the bench computes itself. The bench also measures the beat count and the latency from the last beat to done.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int unsigned FIELD_W = 16;

  typedef struct packed {
    logic               clear;
    logic               accum;
    logic [FIELD_W-1:0] accCount;
    logic               fold;
    logic [FIELD_W-1:0] halfLen;
  } vsr_strobe_t;
endpackage

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int unsigned VL    = 64,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             opValid_i,
  output logic             opReady_o,
  output logic             done_o,
  output vsr_strobe_t      strobe_o
);
  localparam int unsigned LOG = $clog2(VL);
  localparam logic [CNT_W-1:0] VL_C = CNT_W'(VL);
  localparam logic [CNT_W-1:0] REM_MASK = CNT_W'(VL - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACCUM, S_FOLD, S_DONE} state_t;

  state_t           state;
  logic [CNT_W-1:0] remLen;
  logic [CNT_W-1:0] curCnt;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] firstCnt;

  assign firstCnt  = ((len_i & REM_MASK) == '0) ? VL_C : (len_i & REM_MASK);
  assign opReady_o = (state == S_ACCUM);
  assign done_o    = (state == S_DONE);

  always_comb begin
    strobe_o          = '0;
    strobe_o.clear    = (state == S_IDLE) && start_i;
    strobe_o.accum    = (state == S_ACCUM) && opValid_i;
    strobe_o.accCount = FIELD_W'(curCnt);
    strobe_o.fold     = (state == S_FOLD);
    strobe_o.halfLen  = FIELD_W'(halfLen);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      remLen  <= '0;
      curCnt  <= '0;
      halfLen <= '0;
      stepCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          remLen  <= len_i;
          curCnt  <= firstCnt;
          halfLen <= VL_C >> 1;
          stepCnt <= '0;
          state   <= (len_i == '0) ? S_FOLD : S_ACCUM;
        end
        S_ACCUM: if (opValid_i) begin
          remLen <= remLen - curCnt;
          curCnt <= VL_C;
          if (remLen <= curCnt) state <= S_FOLD;
        end
        S_FOLD: begin
          halfLen <= halfLen >> 1;
          stepCnt <= stepCnt + 1'b1;
          if (halfLen <= CNT_W'(1)) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: fold never exceeds log2(VL) steps
  p_fold_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FOLD) |-> (stepCnt < CNT_W'(LOG)));
  // R6: done is reached after exactly log2(VL) steps
  p_fold_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (stepCnt == CNT_W'(LOG)));
  // R8: single-cycle done
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: start during a run leaves the remaining count alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && start_i && !(state == S_ACCUM && opValid_i)) |=> $stable(remLen));
  // R7: zero length never opens the operand port
  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_i && len_i == '0) |=> !opReady_o);
endmodule

// File: rtl/vsr_datapath.sv
module vsr_datapath
  import vsr_pkg::*;
#(
  parameter int unsigned VL     = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vsr_strobe_t          strobe_i,
  input  logic [VL*DATA_W-1:0] opData_i,
  output logic [DATA_W-1:0]    result_o
);
  localparam int unsigned LOG = $clog2(VL);

  logic [DATA_W-1:0] part [VL];

  assign result_o = part[0];

  for (genvar i = 0; i < VL; i++) begin : g_lane
    logic [DATA_W-1:0] partner;
    logic              inChunk;
    logic              inFold;

    assign inChunk = (FIELD_W'(i) < strobe_i.accCount);
    assign inFold  = (FIELD_W'(i) < strobe_i.halfLen);

    always_comb begin
      partner = '0;
      for (int k = 0; k < LOG; k++) begin
        if (strobe_i.halfLen == FIELD_W'(VL >> (k + 1)))
          partner = part[(i + (VL >> (k + 1))) % VL];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || strobe_i.clear)
        part[i] <= '0;
      else if (strobe_i.accum && inChunk)
        part[i] <= part[i] + opData_i[i*DATA_W +: DATA_W];
      else if (strobe_i.fold && inFold)
        part[i] <= part[i] + partner;
    end

    // R3: lanes outside a short chunk keep their partial
    p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i.accum && !strobe_i.clear && !inChunk) |=> $stable(part[i]));
    // R10: a start clears every partial
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i.clear |=> (part[i] == '0));
  end
endmodule

// File: rtl/vec_sum_reduce.sv
module vec_sum_reduce
  import vsr_pkg::*;
#(
  parameter int unsigned VL     = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     len_i,
  input  logic                 opValid_i,
  output logic                 opReady_o,
  input  logic [VL*DATA_W-1:0] opData_i,
  output logic [DATA_W-1:0]    result_o,
  output logic                 done_o
);
  vsr_strobe_t strobe;

  vsr_ctrl #(.VL(VL), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .len_i     (len_i),
    .opValid_i (opValid_i),
    .opReady_o (opReady_o),
    .done_o    (done_o),
    .strobe_o  (strobe)
  );

  vsr_datapath #(.VL(VL), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe),
    .opData_i (opData_i),
    .result_o (result_o)
  );

  initial begin
    p_vl_pow2_r6: assert ((VL >= 2) && ((VL & (VL - 1)) == 0));
  end
endmodule

// File: tb/vec_sum_reduce_tb_top.sv
module vec_sum_reduce_tb_top;
  localparam int VL = 4;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int LOG = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic start_i = 0;
  logic [CW-1:0] len_i = '0;
  logic opValid_i = 0;
  logic opReady_o;
  logic [VL*DW-1:0] opData_i = '0;
  logic [DW-1:0] result_o;
  logic done_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_sum_reduce #(.VL(VL), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .opValid_i(opValid_i), .opReady_o(opReady_o), .opData_i(opData_i),
    .result_o(result_o), .done_o(done_o)
  );

  function automatic logic [DW-1:0] elem(int k, int seed);
    return DW'(k * 37 + seed * 11 + 200);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_one(int n, int seed, bit midStart, bit bubbles);
    int r = n % VL;
    int beatsExp = (n + VL - 1) / VL;
    int expSum = 0;
    int beats = 0;
    int accCyc;
    int guard = 0;
    int readySeen = 0;
    bit injected = 0;
    for (int k = 0; k < n; k++) expSum += int'(elem(k, seed));
    expSum = expSum % (1 << DW);

    @(negedge clk);
    start_i = 1; len_i = CW'(n);
    accCyc = cyc + 1;
    @(negedge clk);
    start_i = 0;
    while (!done_o && guard < 2000) begin
      guard++;
      if (opReady_o) readySeen++;
      start_i = 0;
      if (midStart && !injected && beats == 1) begin
        start_i = 1; len_i = CW'(1); injected = 1;
      end
      if (opReady_o && !(bubbles && (guard % 3 == 1))) begin
        int cnt = (beats == 0 && r != 0) ? r : VL;
        int base = (beats == 0) ? 0 : ((r == 0) ? beats * VL : r + (beats - 1) * VL);
        opValid_i = 1;
        for (int j = 0; j < VL; j++)
          opData_i[j*DW +: DW] = (j < cnt) ? elem(base + j, seed) : DW'(8'hC3 ^ j);
        beats++;
        accCyc = cyc + 1;
      end else begin
        opValid_i = 0;
        opData_i = '1;
      end
      @(negedge clk);
      opValid_i = 0;
    end
    start_i = 0;
    check(done_o == 1'b1, "R8 done seen", int'(done_o), 1);
    check(int'(result_o) == expSum, (n % VL != 0) ? "R3/R5 result" : "R4/R5 result",
          int'(result_o), expSum);
    check(beats == beatsExp, "R2 beat count", beats, beatsExp);
    check(cyc - accCyc == LOG, (n == 0) ? "R7 zero-length latency" : "R6 fold latency",
          cyc - accCyc, LOG);
    if (n == 0) check(readySeen == 0, "R7 no ready", readySeen, 0);
    if (midStart) check(injected, "R9 mid start injected", int'(injected), 1);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done low in reset", int'(done_o), 0);
    check(opReady_o == 1'b0, "R1 ready low in reset", int'(opReady_o), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0 && opReady_o == 1'b0, "R1 idle after reset",
          int'(done_o) + int'(opReady_o), 0);
    for (int n = 0; n <= 17; n++) run_one(n, n + 1, 0, 0);
    for (int n = 1; n <= 13; n++) run_one(n, 3 * n, 0, 1);
    run_one(10, 7, 1, 0);
    run_one(9, 5, 1, 1);
    run_one(255, 9, 0, 0);
    run_one(252, 2, 0, 1);
    // R10: back-to-back short runs, residue must not carry over
    run_one(7, 99, 0, 0);
    run_one(1, 4, 0, 0);
    finished = 1;
    summary();
  end
endmodule